// File: doc/BRIEF.md
# Function-Select 16-Bit ALU

A purely combinational 16-bit arithmetic/logic unit. A 5-bit function code selects one of 32 operations. Even codes are arithmetic and odd codes are logical. Every operation first reduces the operands A and B to two terms, X and Y. The terms are drawn from A, B, their complements and their AND/OR combinations, or from the constants zero and all-ones.

- A logical operation returns X XOR Y.
- An arithmetic operation returns X + Y + carry-in.

The addition is split into two parts. A 4-bit low nibble is summed with the carry-in first. Its carry then feeds the upper 12 bits. A force input can insert a carry into bit 4 whether or not the nibble produced one.

The signed-carry output is the XOR of five bits: the function-code MSB, the sign bits of A, B and the result, and the carry-out. This equals true two's-complement overflow for A+B and for A−B. The block is placed between operand selection and the result register of a datapath. It has no clock or reset.

Top module: `alu16_fsel`

## Requirements
- R1: The arithmetic flag output is 1 for every even function code and 0 for every odd code.
- R2: Odd codes (octal) give: 1 ~A, 3 ~(A&B), 5 ~(A&~B), 7 all-ones, 11 ~(A|B), 13 ~B, 15 A^~B, 17 A|~B, 21 ~(A|~B), 23 A^B, 25 B, 27 A|B, 31 zero, 33 A&~B, 35 A&B, 37 A.
- R3: Even codes (octal) give X+Y+cin modulo 2^16, with (X,Y): 0 (A,0), 2 (A,A&~B), 4 (A,A&B), 6 (A,A), 10 (A|B,0), 12 (A|B,A&~B), 14 (A,B), 16 (A,A|B), 20 (A|~B,0), 22 (A,~B), 24 (A|~B,A&B), 26 (A,A|~B), 30 (all-ones,0), 32 (A&~B,all-ones), 34 (A&B,all-ones), 36 (A,all-ones).
- R4: In arithmetic mode the low 4 bits are X[3:0]+Y[3:0]+cin. With the force input high, bits 15:4 of the result are X[15:4]+Y[15:4]+1. With it low, the natural nibble carry is used. For example, code 0 with A=0, cin=0 and force=1 gives 0x0010.
- R5: In arithmetic mode, carry-out is the carry out of bit 15 of the two-part sum. For example, A+B (code 14) with A=0xFFFF and B=1 gives result 0 and carry-out 1.
- R6: In arithmetic mode, signed-carry = code[4] ^ A[15] ^ B[15] ^ result[15] ^ carry-out. For A+B (code 14) and A+~B+1 (code 22, cin=1), this equals signed overflow.
- R7: For odd codes, both carry-out and signed-carry are 0.
- R8: Outputs follow input changes with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B |
| func_i | input | 5 | Function code; bit 0 low = arithmetic |
| cin_i | input | 1 | Carry into bit 0 (arithmetic only) |
| nib_force_i | input | 1 | Forces a carry into bit 4 (arithmetic only) |
| result_o | output | 16 | Operation result |
| cout_o | output | 1 | Carry out of bit 15; 0 on logical codes |
| ovf_o | output | 1 | Five-way XOR signed-carry; 0 on logical codes |
| arith_o | output | 1 | 1 when the code is arithmetic |

## Verification
The block holds no state, so any wrong decode or carry path shows at the ports in the same evaluation as the stimulus.

- A misrouted term selection corrupts `result_o` for only the codes that share that term, which is why all 32 codes are swept.
- A broken nibble carry or force path is visible only in `result_o` bits 15:4. It shows only for some carry-in, force and low-nibble combinations, which directed vectors cover.
- A wrong gating of the flags shows as nonzero `cout_o` or `ovf_o` on an odd code.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [3:0] {
    TERM_A,
    TERM_B,
    TERM_NB,
    TERM_A_AND_NB,
    TERM_A_AND_B,
    TERM_A_OR_NB,
    TERM_A_OR_B,
    TERM_ZERO,
    TERM_ONES
  } term_sel_e;

  typedef struct packed {
    term_sel_e x;
    term_sel_e y;
  } term_pair_t;

  // Term table: odd codes are X^Y, even codes are X+Y+cin.
  function automatic term_pair_t decode_terms(input logic [4:0] code);
    term_pair_t p;
    unique case (code)
      5'o00: p = '{TERM_A,        TERM_ZERO};
      5'o01: p = '{TERM_A,        TERM_ONES};
      5'o02: p = '{TERM_A,        TERM_A_AND_NB};
      5'o03: p = '{TERM_A_AND_B,  TERM_ONES};
      5'o04: p = '{TERM_A,        TERM_A_AND_B};
      5'o05: p = '{TERM_A_AND_NB, TERM_ONES};
      5'o06: p = '{TERM_A,        TERM_A};
      5'o07: p = '{TERM_ZERO,     TERM_ONES};
      5'o10: p = '{TERM_A_OR_B,   TERM_ZERO};
      5'o11: p = '{TERM_A_OR_B,   TERM_ONES};
      5'o12: p = '{TERM_A_OR_B,   TERM_A_AND_NB};
      5'o13: p = '{TERM_B,        TERM_ONES};
      5'o14: p = '{TERM_A,        TERM_B};
      5'o15: p = '{TERM_A,        TERM_NB};
      5'o16: p = '{TERM_A,        TERM_A_OR_B};
      5'o17: p = '{TERM_A_OR_NB,  TERM_ZERO};
      5'o20: p = '{TERM_A_OR_NB,  TERM_ZERO};
      5'o21: p = '{TERM_A_OR_NB,  TERM_ONES};
      5'o22: p = '{TERM_A,        TERM_NB};
      5'o23: p = '{TERM_A,        TERM_B};
      5'o24: p = '{TERM_A_OR_NB,  TERM_A_AND_B};
      5'o25: p = '{TERM_B,        TERM_ZERO};
      5'o26: p = '{TERM_A,        TERM_A_OR_NB};
      5'o27: p = '{TERM_A_OR_B,   TERM_ZERO};
      5'o30: p = '{TERM_ONES,     TERM_ZERO};
      5'o31: p = '{TERM_ZERO,     TERM_ZERO};
      5'o32: p = '{TERM_A_AND_NB, TERM_ONES};
      5'o33: p = '{TERM_A_AND_NB, TERM_ZERO};
      5'o34: p = '{TERM_A_AND_B,  TERM_ONES};
      5'o35: p = '{TERM_A_AND_B,  TERM_ZERO};
      5'o36: p = '{TERM_A,        TERM_ONES};
      default: p = '{TERM_A,      TERM_ZERO};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/alu16_terms.sv
module alu16_terms
  import alu16_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int FUNC_W = 5
) (
  input  logic [WIDTH-1:0]  a_i,
  input  logic [WIDTH-1:0]  b_i,
  input  logic [FUNC_W-1:0] func_i,
  output logic [WIDTH-1:0]  x_o,
  output logic [WIDTH-1:0]  y_o,
  output logic              arith_o
);

  localparam int NUM_TERMS = 9;

  logic [WIDTH-1:0] term_val [NUM_TERMS];
  term_pair_t       sel;

  always_comb begin
    term_val[TERM_A]        = a_i;
    term_val[TERM_B]        = b_i;
    term_val[TERM_NB]       = ~b_i;
    term_val[TERM_A_AND_NB] = a_i & ~b_i;
    term_val[TERM_A_AND_B]  = a_i & b_i;
    term_val[TERM_A_OR_NB]  = a_i | ~b_i;
    term_val[TERM_A_OR_B]   = a_i | b_i;
    term_val[TERM_ZERO]     = '0;
    term_val[TERM_ONES]     = '1;
  end

  always_comb begin
    sel     = decode_terms(func_i[4:0]);
    x_o     = term_val[sel.x];
    y_o     = term_val[sel.y];
    arith_o = ~func_i[0];
  end

endmodule

// File: rtl/alu16_split_adder.sv
module alu16_split_adder #(
  parameter int WIDTH = 16,
  parameter int LOW_W = 4
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  input  logic             nib_force_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  localparam int HI_W = WIDTH - LOW_W;

  logic [LOW_W:0] low_sum;
  logic           nib_carry;
  logic [HI_W:0]  hi_sum;

  always_comb begin
    low_sum   = {1'b0, x_i[LOW_W-1:0]} + {1'b0, y_i[LOW_W-1:0]}
              + {{LOW_W{1'b0}}, cin_i};
    nib_carry = low_sum[LOW_W] | nib_force_i;
    hi_sum    = {1'b0, x_i[WIDTH-1:LOW_W]} + {1'b0, y_i[WIDTH-1:LOW_W]}
              + {{HI_W{1'b0}}, nib_carry};
    sum_o     = {hi_sum[HI_W-1:0], low_sum[LOW_W-1:0]};
    cout_o    = hi_sum[HI_W];
  end

  // R4
  always_comb begin
    if (!nib_force_i && !cin_i && (x_i[LOW_W-1:0] == '0))
      nib_natural_chk: assert (sum_o[LOW_W-1:0] == y_i[LOW_W-1:0]);
  end

endmodule

// File: rtl/alu16_flags.sv
module alu16_flags (
  input  logic func_msb_i,
  input  logic a_msb_i,
  input  logic b_msb_i,
  input  logic sum_msb_i,
  input  logic carry_i,
  input  logic arith_i,
  output logic cout_o,
  output logic ovf_o
);

  always_comb begin
    cout_o = arith_i & carry_i;
    ovf_o  = arith_i & (func_msb_i ^ a_msb_i ^ b_msb_i ^ sum_msb_i ^ carry_i);
  end

endmodule

// File: rtl/alu16_fsel.sv
module alu16_fsel
  import alu16_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int LOW_W  = 4,
  parameter int FUNC_W = 5
) (
  input  logic [WIDTH-1:0]  a_i,
  input  logic [WIDTH-1:0]  b_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic              cin_i,
  input  logic              nib_force_i,
  output logic [WIDTH-1:0]  result_o,
  output logic              cout_o,
  output logic              ovf_o,
  output logic              arith_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] x_term, y_term, sum;
  logic             sum_carry, arith;

  alu16_terms #(.WIDTH(WIDTH), .FUNC_W(FUNC_W)) u_terms (
    .a_i     (a_i),
    .b_i     (b_i),
    .func_i  (func_i),
    .x_o     (x_term),
    .y_o     (y_term),
    .arith_o (arith)
  );

  alu16_split_adder #(.WIDTH(WIDTH), .LOW_W(LOW_W)) u_adder (
    .x_i         (x_term),
    .y_i         (y_term),
    .cin_i       (cin_i),
    .nib_force_i (nib_force_i),
    .sum_o       (sum),
    .cout_o      (sum_carry)
  );

  alu16_flags u_flags (
    .func_msb_i (func_i[FUNC_W-1]),
    .a_msb_i    (a_i[MSB]),
    .b_msb_i    (b_i[MSB]),
    .sum_msb_i  (sum[MSB]),
    .carry_i    (sum_carry),
    .arith_i    (arith),
    .cout_o     (cout_o),
    .ovf_o      (ovf_o)
  );

  always_comb begin
    result_o = arith ? sum : (x_term ^ y_term);
    arith_o  = arith;
  end

  always_comb begin
    // R1
    arith_parity_chk: assert (arith_o != func_i[0]);
    // R7
    if (!arith_o) logic_flags_zero_chk: assert (!cout_o && !ovf_o);
    // R5
    if (func_i == 5'o14 && !nib_force_i)
      add_carry_chk: assert ({cout_o, result_o} ==
                             ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}));
    // R6
    if (func_i == 5'o14)
      add_overflow_chk: assert (ovf_o ==
                                ((a_i[MSB] == b_i[MSB]) && (result_o[MSB] != a_i[MSB])));
    // R4
    if (arith_o && nib_force_i)
      force_upper_chk: assert (result_o[MSB:LOW_W] ==
                               x_term[MSB:LOW_W] + y_term[MSB:LOW_W] + 1'b1);
  end

endmodule

// File: tb/test_alu16_fsel.sv
module test_alu16_fsel;

  logic        clk = 1'b0;
  logic [15:0] a, b;
  logic [4:0]  func;
  logic        cin, frc;
  logic [15:0] result;
  logic        cout, ovf, arith;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  alu16_fsel i_alu16_fsel (
    .a_i(a), .b_i(b), .func_i(func), .cin_i(cin), .nib_force_i(frc),
    .result_o(result), .cout_o(cout), .ovf_o(ovf), .arith_o(arith)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h (func=%o a=%h b=%h cin=%b frc=%b)",
               tag, act, exp, func, a, b, cin, frc);
    end
  endtask

  // Behavioural model from the function table.
  task automatic model(input int ia, input int ib, input int f, input int c, input int fr,
                       output int r, output int co, output int ov, output int ar);
    int na, nb, x, y, lo, full;
    na = ~ia & 16'hFFFF;
    nb = ~ib & 16'hFFFF;
    ar = (f % 2 == 0) ? 1 : 0;
    co = 0; ov = 0;
    if (ar == 0) begin
      case (f)
        'o01: r = na;
        'o03: r = ~(ia & ib);
        'o05: r = ~(ia & nb);
        'o07: r = 16'hFFFF;
        'o11: r = ~(ia | ib);
        'o13: r = nb;
        'o15: r = ~(ia ^ ib);
        'o17: r = ia | nb;
        'o21: r = ~(ia | nb);
        'o23: r = ia ^ ib;
        'o25: r = ib;
        'o27: r = ia | ib;
        'o31: r = 0;
        'o33: r = ia & nb;
        'o35: r = ia & ib;
        default: r = ia;
      endcase
      r = r & 16'hFFFF;
    end else begin
      case (f)
        'o00: begin x = ia;        y = 0;         end
        'o02: begin x = ia;        y = ia & nb;   end
        'o04: begin x = ia;        y = ia & ib;   end
        'o06: begin x = ia;        y = ia;        end
        'o10: begin x = ia | ib;   y = 0;         end
        'o12: begin x = ia | ib;   y = ia & nb;   end
        'o14: begin x = ia;        y = ib;        end
        'o16: begin x = ia;        y = ia | ib;   end
        'o20: begin x = ia | nb;   y = 0;         end
        'o22: begin x = ia;        y = nb;        end
        'o24: begin x = ia | nb;   y = ia & ib;   end
        'o26: begin x = ia;        y = ia | nb;   end
        'o30: begin x = 16'hFFFF;  y = 0;         end
        'o32: begin x = ia & nb;   y = 16'hFFFF;  end
        'o34: begin x = ia & ib;   y = 16'hFFFF;  end
        default: begin x = ia;     y = 16'hFFFF;  end
      endcase
      lo = (x % 16) + (y % 16) + c;
      if (fr != 0) lo = lo | 16;
      full = (x / 16) * 16 + (y / 16) * 16 + lo;
      r  = full % 65536;
      co = full / 65536;
      ov = ((f / 16) + (ia / 32768) + (ib / 32768) + (r / 32768) + co) % 2;
    end
  endtask

  task automatic apply_and_check(input int ia, input int ib, input int f, input int c, input int fr);
    int r, co, ov, ar;
    @(negedge clk);
    a = ia[15:0]; b = ib[15:0]; func = f[4:0]; cin = c[0]; frc = fr[0];
    #1;
    model(ia, ib, f, c, fr, r, co, ov, ar);
    check(ar != 0 ? (fr != 0 ? "R3/R4 result" : "R3 result") : "R2 result", int'(result), r);
    check("R1 arith flag", int'(arith), ar);
    check(ar != 0 ? "R5 carry" : "R7 carry", int'(cout), co);
    check(ar != 0 ? "R6 ovf" : "R7 ovf", int'(ovf), ov);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; func = '0; cin = 1'b0; frc = 1'b0;
    #2;
    // initial state with all-zero inputs
    check("R3 idle result", int'(result), 0);
    check("R1 idle arith", int'(arith), 1);

    // R4: forced nibble carry on 0+0
    apply_and_check(0, 0, 'o00, 0, 1);
    check("R4 forced carry 0x0010", int'(result), 16'h0010);
    // R4: natural nibble carry, force redundant
    apply_and_check(16'h000F, 1, 'o14, 0, 1);
    check("R4 force with natural carry", int'(result), 16'h0010);
    apply_and_check(16'h000F, 1, 'o14, 0, 0);
    check("R4 natural carry", int'(result), 16'h0010);
    // R5: wrap
    apply_and_check(16'hFFFF, 1, 'o14, 0, 0);
    check("R5 cout on wrap", int'(cout), 1);
    check("R5 zero on wrap", int'(result), 0);
    // R6: true overflow cases
    apply_and_check(16'h7FFF, 1, 'o14, 0, 0);
    check("R6 add overflow", int'(ovf), 1);
    apply_and_check(16'h8000, 1, 'o22, 1, 0);
    check("R6 sub overflow", int'(ovf), 1);
    apply_and_check(5, 3, 'o22, 1, 0);
    check("R6 sub no overflow", int'(ovf), 0);
    check("R3 5-3", int'(result), 2);
    // R7: logical code with would-be carry
    apply_and_check(16'hFFFF, 16'hFFFF, 'o23, 1, 1);
    check("R7 logic cout", int'(cout), 0);

    // R8: change inputs without any clock edge
    @(negedge clk);
    a = 16'h1234; b = 16'h00FF; func = 5'o35; cin = 0; frc = 0;
    #1 check("R8 first", int'(result), 16'h0034);
    func = 5'o27;
    #1 check("R8 second", int'(result), 16'h12FF);

    // R2 R3 sweep
    for (int f = 0; f < 32; f++)
      for (int k = 0; k < 40; k++) begin
        int ia, ib;
        ia = int'($urandom() % 65536);
        ib = int'($urandom() % 65536);
        if (k == 0) begin ia = 0;      ib = 0;      end
        if (k == 1) begin ia = 'hFFFF; ib = 'hFFFF; end
        if (k == 2) begin ia = 'h8000; ib = 'h7FFF; end
        apply_and_check(ia, ib, f, k % 2, (k / 2) % 2);
      end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule